// File: doc/BRIEF.md
# Cache line zero engine

The engine carries out a "zero data cache block" command for a processor's load/store unit. It takes an effective address and a line size, rounds the address down to the start of the enclosing line, and walks the line with a burst of 32-bit stores of zero. The stores go out on a simple request port with a valid/ready handshake, one word per accepted transfer, in ascending address order. When the burst is complete, the engine compares the aligned line address with the processor's load-reserved reservation address. If the two match, it cancels the reservation by setting it to all ones.

The line size comes from a 3-bit select, so it is always a power of two between 16 and 256 bytes. A 2-bit implementation mode field can shrink the line to 32 bytes for the plain zero command only; the long-line variant of the command always uses the configured size. The same engine also runs an instruction-block invalidate probe. For that command it aligns the address in the same way, issues a single 32-bit read that is treated as a data load, and waits for the read response.

The reservation register sits inside the block. A set port loads it when a load-reserved completes, and it is visible as an output. A command is accepted only while the engine is idle, and the done output pulses once per command.

Top module: `line_zero_engine`

## Requirements
- R1: After reset, cmd_ready is 1, mem_req_valid is 0, done is 0 and resv_addr is all ones.
- R2: cfg_line_sel value s selects a line of 16<<s bytes for s = 0..4 (16, 32, 64, 128, 256); values 5, 6 and 7 select 256 bytes.
- R3: A zero command (cmd_probe=0) issues stores with mem_req_we=1 and mem_req_wdata=0 to base, base+4, ..., base+line-4, in that order and one per accepted handshake. Here base = cmd_addr AND NOT(line-1). While a request is not accepted, its address and direction hold.
- R4: When cmd_long=0 and cmd_probe=0, cfg_impl_mode==2'b01 forces a 32-byte line. With cmd_long=1, or with any other mode value, the cfg_line_sel size is used. The mode field has no effect on probe commands.
- R5: A probe command (cmd_probe=1, cmd_long ignored) issues exactly one read (mem_req_we=0) at the address aligned to the cfg_line_sel line, and then waits for mem_rsp_valid.
- R6: done is high for exactly one cycle. For a zero command it is the cycle after the final store is accepted; for a probe it is the cycle after mem_rsp_valid is seen.
- R7: In the done cycle of a zero command, if resv_addr equals the aligned base, resv_addr becomes all ones in the next cycle. Otherwise it is unchanged. A probe never changes it.
- R8: resv_set_valid loads resv_set_addr into resv_addr, visible the next cycle. A set in the done cycle wins over the cancel of R7.
- R9: A command is taken only in a cycle where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from acceptance through the done cycle, and cmd_valid asserted while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | ADDR_W | Effective address of the command |
| cmd_probe | input | 1 | 1: instruction-block invalidate probe, 0: zero line |
| cmd_long | input | 1 | Long-line zero variant (mode override not applied) |
| cfg_line_sel | input | 3 | Line size select, 16<<s bytes, saturating at 256 |
| cfg_impl_mode | input | 2 | Implementation mode; 2'b01 selects the 32-byte override |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 store, 0 load |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_wdata | output | 32 | Store data, always zero |
| mem_rsp_valid | input | 1 | Read response for the probe |
| resv_set_valid | input | 1 | Load a new reservation |
| resv_set_addr | input | ADDR_W | Reservation address to load |
| resv_addr | output | ADDR_W | Current reservation address, all ones when none |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the request protocol on every cycle. They cover several points: a stalled request holds its address, each accepted store is followed by one 4 bytes higher, and the probe issues a single read. They also check that done follows the last store and lasts one cycle, that the reservation set and cancel rules hold, and that the engine is never ready while done is high. Other behaviours only show up in the bench's scenarios: the aligned base and the word count for each line select, the 32-byte override and the cases it must not touch, the matching and non-matching reservation cases, the collision of a set with a cancel, and commands offered while busy.

// File: rtl/line_zero_pkg.sv
package line_zero_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ZERO  = 3'd1,
    ST_PROBE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FIN   = 3'd4
  } lz_state_e;

  // log2 of the line size from the select code, saturating at max_l
  function automatic int unsigned sel_to_log2(input int unsigned sel,
                                              input int unsigned min_l,
                                              input int unsigned max_l);
    int unsigned v;
    v = min_l + sel;
    return (v > max_l) ? max_l : v;
  endfunction

  // mask of the offset bits inside a line
  function automatic logic [63:0] low_mask(input int unsigned lg);
    return (64'd1 << lg) - 64'd1;
  endfunction

  // byte offset of the last word in a line
  function automatic int unsigned last_word_off(input int unsigned lg);
    return (32'd1 << lg) - 32'd4;
  endfunction

endpackage

// File: rtl/line_zero_calc.sv
module line_zero_calc
  import line_zero_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 3,
  parameter int MIN_LOG2   = 4,
  parameter int MAX_LOG2   = 8,
  parameter int SHORT_LOG2 = 5,
  parameter int LOG_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        mode_i,
  input  logic              long_i,
  input  logic              probe_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LOG_W-1:0]  log2_o
);

  logic [LOG_W-1:0] cfg_log2;
  logic             use_short;
  logic [63:0]      mask_w;

  assign cfg_log2  = LOG_W'(sel_to_log2(int'(sel_i), MIN_LOG2, MAX_LOG2));
  assign use_short = !probe_i && !long_i && (mode_i == 2'b01);
  assign log2_o    = use_short ? LOG_W'(SHORT_LOG2) : cfg_log2;
  assign mask_w    = low_mask(int'(log2_o));
  assign base_o    = addr_i & ~mask_w[ADDR_W-1:0];

endmodule

// File: rtl/line_zero_seq.sv
module line_zero_seq
  import line_zero_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 8,
  parameter int LOG_W    = $clog2(MAX_LOG2 + 1),
  parameter int OFF_W    = MAX_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_probe,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LOG_W-1:0]  log2_i,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic [ADDR_W-1:0] line_base_o,
  output logic              zero_fin_o,
  output logic              done_o
);

  lz_state_e         state_q;
  logic [ADDR_W-1:0] base_q;
  logic [LOG_W-1:0]  log2_q;
  logic [OFF_W-1:0]  off_q;
  logic              zero_q;

  logic              req_accept;
  logic              last_store_acc;
  logic [OFF_W-1:0]  last_off;

  assign last_off       = OFF_W'(last_word_off(int'(log2_q)));
  assign cmd_ready      = (state_q == ST_IDLE);
  assign mem_req_valid  = (state_q == ST_ZERO) || (state_q == ST_PROBE);
  assign mem_req_we     = (state_q == ST_ZERO);
  assign mem_req_addr   = base_q + ADDR_W'(off_q);
  assign mem_req_wdata  = '0;
  assign req_accept     = mem_req_valid && mem_req_ready;
  assign last_store_acc = (state_q == ST_ZERO) && req_accept && (off_q == last_off);
  assign done_o         = (state_q == ST_FIN);
  assign zero_fin_o     = done_o && zero_q;
  assign line_base_o    = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      log2_q  <= '0;
      off_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          base_q  <= base_i;
          log2_q  <= log2_i;
          off_q   <= '0;
          zero_q  <= !cmd_probe;
          state_q <= cmd_probe ? ST_PROBE : ST_ZERO;
        end
        ST_ZERO: if (req_accept) begin
          if (off_q == last_off) state_q <= ST_FIN;
          else                   off_q   <= off_q + OFF_W'(4);
        end
        ST_PROBE: if (req_accept)    state_q <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a stalled request keeps its address and direction
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R3: stores walk upward one word at a time
  a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_we && !last_store_acc
    |=> mem_req_we && mem_req_addr == $past(mem_req_addr) + ADDR_W'(4));

  // R5: the probe issues a single read
  a_r5_one_probe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid);

  // R6: done follows the final store
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_store_acc |=> done_o);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: never ready while finishing
  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_ready);

endmodule

// File: rtl/line_zero_resv.sv
module line_zero_resv #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              zero_fin,
  input  logic [ADDR_W-1:0] line_base,
  output logic [ADDR_W-1:0] resv_q
);

  logic cancel_hit;

  assign cancel_hit = zero_fin && (resv_q == line_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resv_q <= '1;
    else if (set_valid)  resv_q <= set_addr;
    else if (cancel_hit) resv_q <= '1;
  end

  // R8: a set is visible on the next cycle
  a_r8_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> resv_q == $past(set_addr));

  // R7: a matching zeroed line cancels the reservation
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fin && (resv_q == line_base) && !set_valid |=> resv_q == '1);

  // R7: nothing else touches the reservation
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !set_valid && !zero_fin |=> $stable(resv_q));

endmodule

// File: rtl/line_zero_engine.sv
module line_zero_engine
  import line_zero_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 3,
  parameter int MIN_LOG2   = 4,
  parameter int MAX_LOG2   = 8,
  parameter int SHORT_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_probe,
  input  logic              cmd_long,
  input  logic [SEL_W-1:0]  cfg_line_sel,
  input  logic [1:0]        cfg_impl_mode,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              resv_set_valid,
  input  logic [ADDR_W-1:0] resv_set_addr,
  output logic [ADDR_W-1:0] resv_addr,
  output logic              done
);

  localparam int LOG_W = $clog2(MAX_LOG2 + 1);

  logic [ADDR_W-1:0] cmd_base;
  logic [LOG_W-1:0]  cmd_log2;
  logic [ADDR_W-1:0] line_base;
  logic              zero_fin;

  line_zero_calc #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2), .SHORT_LOG2(SHORT_LOG2), .LOG_W(LOG_W)
  ) calc_i (
    .addr_i(cmd_addr), .sel_i(cfg_line_sel), .mode_i(cfg_impl_mode),
    .long_i(cmd_long), .probe_i(cmd_probe),
    .base_o(cmd_base), .log2_o(cmd_log2)
  );

  line_zero_seq #(
    .ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W), .OFF_W(MAX_LOG2)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_probe(cmd_probe),
    .base_i(cmd_base), .log2_i(cmd_log2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .line_base_o(line_base), .zero_fin_o(zero_fin), .done_o(done)
  );

  line_zero_resv #(.ADDR_W(ADDR_W)) resv_i (
    .clk(clk), .rst_n(rst_n),
    .set_valid(resv_set_valid), .set_addr(resv_set_addr),
    .zero_fin(zero_fin), .line_base(line_base), .resv_q(resv_addr)
  );

  // R3: store data is always zero whenever a store is offered
  a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata == 32'd0);

endmodule

// File: tb/line_zero_engine_tb_top.sv
module line_zero_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_probe = 1'b0, cmd_long = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [2:0]  cfg_line_sel = '0;
  logic [1:0]  cfg_impl_mode = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic        resv_set_valid = 1'b0;
  logic [31:0] resv_set_addr = '0;
  logic        cmd_ready, mem_req_valid, mem_req_we, done;
  logic [31:0] mem_req_addr, mem_req_wdata, resv_addr;

  int n_chk = 0;
  int n_bad = 0;
  int tick = 0;

  always #4 clk = ~clk;

  line_zero_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_probe(cmd_probe), .cmd_long(cmd_long),
    .cfg_line_sel(cfg_line_sel), .cfg_impl_mode(cfg_impl_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .resv_set_valid(resv_set_valid), .resv_set_addr(resv_set_addr),
    .resv_addr(resv_addr), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // R2/R4 restated: line log2 for a command
  function automatic int exp_log2(input logic [2:0] sel, input logic [1:0] mode,
                                  input bit lng, input bit prb);
    if (!prb && !lng && mode == 2'b01) return 5;
    if (sel >= 3'd4) return 8;
    return 4 + int'(sel);
  endfunction

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // rk: 0 reservation on base, 1 off by a word, 2 random
  task automatic run_cmd(input logic [31:0] a, input logic [2:0] sel, input logic [1:0] mode,
                         input bit lng, input bit prb, input int rk,
                         input bit collide, input bit junk);
    int lg, nst, nrd, cyc, acc_cyc, done_cyc, rsp_at, busy_rdy;
    logic [31:0] base, rv, coll, exp_rv;
    bit bad_addr;
    lg = exp_log2(sel, mode, lng, prb);
    base = a & ~((32'd1 << lg) - 32'd1);
    rv = (rk == 0) ? base : (rk == 1) ? base + 32'd4 : $urandom;
    coll = $urandom;
    @(negedge clk);
    resv_set_valid = 1'b1; resv_set_addr = rv;
    @(negedge clk);
    resv_set_valid = 1'b0;
    #1 chk(resv_addr == rv, "R8 reservation load", resv_addr, rv);
    chk(cmd_ready == 1'b1, "R9 idle ready", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_addr = a; cfg_line_sel = sel; cfg_impl_mode = mode;
    cmd_long = lng; cmd_probe = prb;
    @(negedge clk);
    if (junk) begin
      cmd_addr = ~a; cmd_probe = ~prb; cfg_line_sel = ~sel; cfg_impl_mode = 2'b01;
    end else cmd_valid = 1'b0;
    nst = 0; nrd = 0; cyc = 0; acc_cyc = -10; done_cyc = -1; rsp_at = -10;
    busy_rdy = 0; bad_addr = 0;
    while (cyc < 3000) begin
      mem_req_ready = ($urandom % 3) != 0;
      mem_rsp_valid = (cyc == rsp_at);
      #1;
      if (done) begin done_cyc = cyc; break; end
      if (cmd_ready) busy_rdy++;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (mem_req_addr != base + 32'(4 * nst) || mem_req_wdata != 0) bad_addr = 1;
          nst++;
        end else begin
          if (mem_req_addr != base) bad_addr = 1;
          nrd++;
          rsp_at = cyc + 1 + int'($urandom % 3);
        end
        acc_cyc = cyc;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    if (collide) begin resv_set_valid = 1'b1; resv_set_addr = coll; end
    chk(!bad_addr, "R3/R5 request address sequence", 32'(bad_addr), 32'd0);
    chk(busy_rdy == 0, "R9 ready low while busy", 32'(busy_rdy), 32'd0);
    if (prb) begin
      chk(nst == 0 && nrd == 1, "R5 single probe read", 32'(nrd + 16 * nst), 32'd1);
      chk(done_cyc == rsp_at + 1, "R6 done after response", 32'(done_cyc), 32'(rsp_at + 1));
    end else begin
      chk(nst == (1 << (lg - 2)) && nrd == 0, "R2/R4 store count", 32'(nst), 32'(1 << (lg - 2)));
      chk(done_cyc == acc_cyc + 1, "R6 done after last store", 32'(done_cyc), 32'(acc_cyc + 1));
    end
    exp_rv = collide ? coll : (!prb && rv == base) ? 32'hFFFF_FFFF : rv;
    @(negedge clk);
    resv_set_valid = 1'b0;
    #1;
    chk(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    chk(resv_addr == exp_rv, "R7/R8 reservation after command", resv_addr, exp_rv);
    chk(mem_req_valid == 1'b0, "R9 no request from busy command", 32'(mem_req_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd8121));
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready == 1'b1, "R1 reset ready", 32'(cmd_ready), 32'd1);
    chk(mem_req_valid == 1'b0, "R1 reset no request", 32'(mem_req_valid), 32'd0);
    chk(done == 1'b0, "R1 reset done low", 32'(done), 32'd0);
    chk(resv_addr == 32'hFFFF_FFFF, "R1 reset reservation", resv_addr, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: every select code, plain zero, no override
    for (int s = 0; s < 8; s++) run_cmd(32'h0000_1234 + 32'(s * 32'h1000), 3'(s), 2'b00, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    // R4: override applies to the plain zero only
    run_cmd(32'h0000_5F7C, 3'd4, 2'b01, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    run_cmd(32'h0000_5F7C, 3'd4, 2'b01, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    run_cmd(32'h0000_5F7C, 3'd2, 2'b10, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    run_cmd(32'h0000_5F7C, 3'd2, 2'b11, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    // R5: probe ignores mode and long flag; reservation untouched
    run_cmd(32'h0000_ABCD, 3'd3, 2'b01, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    run_cmd(32'hFFFF_FFFF, 3'd0, 2'b00, 1'b0, 1'b1, 0, 1'b0, 1'b0);
    // R7: non-matching reservation stays; top of address space
    run_cmd(32'hFFFF_FFF3, 3'd7, 2'b00, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    run_cmd(32'hFFFF_FFF3, 3'd1, 2'b00, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    // R8: set in the done cycle wins over the cancel
    run_cmd(32'h0000_0400, 3'd1, 2'b00, 1'b0, 1'b0, 0, 1'b1, 1'b0);
    // R9: commands offered while busy are ignored
    run_cmd(32'h0000_2222, 3'd2, 2'b00, 1'b0, 1'b0, 0, 1'b0, 1'b1);
    run_cmd(32'h0000_3333, 3'd0, 2'b00, 1'b0, 1'b1, 0, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 40; i++)
      run_cmd($urandom, 3'($urandom), 2'($urandom), 1'($urandom), ($urandom % 4) == 0,
              int'($urandom % 3), ($urandom % 5) == 0, ($urandom % 4) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule